// File: doc/BRIEF.md
# Bus Write Beat Pair Assembler

The block sits between a system bus and a memory array controller on the write path. The bus delivers every write as two consecutive 72-bit data beats. The block keeps the first beat until its partner arrives, then joins the pair into one 144-bit memory word and places that word in a two-entry word buffer. The memory side drains the buffer in arrival order through a valid/ready handshake.

The memory side may stall for a refresh, or while it serves a read in the other bank. Because whole words are buffered, the bus can still complete up to two writes during such a stall. A write may arrive in wrapped order, which is flagged by a wrap bit that comes with the first beat. The block then swaps the halves so that the memory always receives the word in natural order. When both word slots are occupied, the block raises a busy flag toward the bus and refuses new writes.

Top module: `wdat_assembler`

## Requirements
- R1: While reset is asserted, and afterwards until the first write completes, mem_vld and bus_busy are low and no partial first beat is held.
- R2: For an unwrapped write (bus_wrap low with the first beat), the first beat appears in mem_word[71:0] and the second beat appears in mem_word[143:72].
- R3: For a wrapped write (bus_wrap high with the first beat), the first beat appears in mem_word[143:72] and the second beat appears in mem_word[71:0]. The value of bus_wrap during the second beat has no effect.
- R4: An assembled word is presented with mem_vld high starting in the cycle after the clock edge that accepts its second beat, provided no older word is waiting ahead of it.
- R5: Words leave on the memory side in the order in which their writes completed on the bus. Each word is delivered exactly once, at a clock edge where mem_vld and mem_rdy are both high.
- R6: While mem_vld is high and mem_rdy is low, mem_vld stays high and mem_word stays unchanged.
- R7: bus_busy is high exactly when two assembled words are waiting for the memory side.
- R8: A beat with bus_vld high that arrives while bus_busy is high and no first beat is held is dropped. It produces no memory word and does not pair with any later beat.
- R9: With mem_rdy held low, the block completes two full writes from the bus. It never holds more than two words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserted asynchronously, released through a two-stage synchronizer |
| bus_vld | input | 1 | A bus write data beat is present this cycle |
| bus_beat | input | 72 | Bus write data beat |
| bus_wrap | input | 1 | Wrapped-order flag; only sampled together with the first beat |
| bus_busy | output | 1 | Both word slots are full; the bus must not start a write |
| mem_vld | output | 1 | An assembled word is offered to the memory side |
| mem_rdy | input | 1 | The memory side takes the offered word at this edge |
| mem_word | output | 144 | Assembled memory write word |

## Verification
The assertions assume that the bus never leaves a write half done. Once a first beat has been accepted, the next valid beat belongs to the same write. A second beat is always accepted, because no new word can be pushed while a first beat is pending. The assertions also assume that mem_rdy is a plain per-cycle acceptance that the memory side may drop at any time. The stimulus drives beats, wrap flags and ready from a seeded generator, and it ignores bus_busy on purpose: a beat offered during busy then tests the drop rule, because the reference model applies that rule the same way.

// File: rtl/wdat_pkg.sv
package wdat_pkg;

  localparam int unsigned WDAT_BEAT_W = 72;
  localparam int unsigned WDAT_DEPTH  = 2;

  typedef enum logic {
    HALF_EMPTY = 1'b0,
    HALF_HELD  = 1'b1
  } half_e;

endpackage

// File: rtl/wdat_beat_stage.sv
module wdat_beat_stage
  import wdat_pkg::*;
#(
  parameter int unsigned BEAT_W = WDAT_BEAT_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  beat_vld,
  input  logic [BEAT_W-1:0]     beat_data,
  input  logic                  beat_wrap,
  input  logic                  stall,
  output logic                  push,
  output logic [2*BEAT_W-1:0]   push_word,
  output logic                  held
);

  half_e             state_q, state_d;
  logic [BEAT_W-1:0] first_q;
  logic              wrap_q;
  logic              take_first;
  logic              take_second;

  // next-state logic
  always_comb begin
    take_first  = beat_vld && (state_q == HALF_EMPTY) && !stall;
    take_second = beat_vld && (state_q == HALF_HELD);
    state_d     = state_q;
    if (take_first) begin
      state_d = HALF_HELD;
    end else if (take_second) begin
      state_d = HALF_EMPTY;
    end
  end

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= HALF_EMPTY;
    end else begin
      state_q <= state_d;
    end
  end

  // first-beat holding register, clock enabled
  always_ff @(posedge clk) begin
    if (take_first) begin
      first_q <= beat_data;
      wrap_q  <= beat_wrap;
    end
  end

  // word assembly: wrapped writes put the first beat in the upper half
  always_comb begin
    push = take_second;
    if (wrap_q) begin
      push_word = {first_q, beat_data};
    end else begin
      push_word = {beat_data, first_q};
    end
  end

  assign held = (state_q == HALF_HELD);

endmodule

// File: rtl/wdat_word_fifo.sv
module wdat_word_fifo
  import wdat_pkg::*;
#(
  parameter int unsigned WORD_W = 2 * WDAT_BEAT_W,
  parameter int unsigned DEPTH  = WDAT_DEPTH
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            push,
  input  logic [WORD_W-1:0]               push_word,
  output logic                            out_vld,
  input  logic                            out_rdy,
  output logic [WORD_W-1:0]               out_word,
  output logic                            full,
  output logic [$clog2(DEPTH+1)-1:0]      fill
);

  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [WORD_W-1:0] slot_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0]  rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              pop;

  // next-state logic
  always_comb begin
    pop      = out_vld && out_rdy;
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (push) begin
      wr_ptr_d = (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
    end
    if (pop) begin
      rd_ptr_d = (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
    end
    if (push && !pop) begin
      cnt_d = cnt_q + 1'b1;
    end else if (pop && !push) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  // pointer and count registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  // one clock-enabled register per word slot
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_en;
    assign slot_en = push && (wr_ptr_q == PTR_W'(g));
    always_ff @(posedge clk) begin
      if (slot_en) begin
        slot_q[g] <= push_word;
      end
    end
  end

  assign out_vld  = (cnt_q != '0);
  assign out_word = slot_q[rd_ptr_q];
  assign full     = (cnt_q == CNT_W'(DEPTH));
  assign fill     = cnt_q;

endmodule

// File: rtl/wdat_assembler.sv
module wdat_assembler
  import wdat_pkg::*;
#(
  parameter int unsigned BEAT_W = WDAT_BEAT_W,
  parameter int unsigned DEPTH  = WDAT_DEPTH
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_vld,
  input  logic [BEAT_W-1:0]     bus_beat,
  input  logic                  bus_wrap,
  output logic                  bus_busy,
  output logic                  mem_vld,
  input  logic                  mem_rdy,
  output logic [2*BEAT_W-1:0]   mem_word
);

  localparam int unsigned WORD_W = 2 * BEAT_W;
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1);

  logic [1:0]        rst_sync_q;
  logic              rst_core_n;
  logic              push;
  logic [WORD_W-1:0] push_word;
  logic              held;
  logic              full;
  logic [CNT_W-1:0]  fill;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync_q[1];

  wdat_beat_stage #(
    .BEAT_W (BEAT_W)
  ) i_stage (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .beat_vld  (bus_vld),
    .beat_data (bus_beat),
    .beat_wrap (bus_wrap),
    .stall     (full),
    .push      (push),
    .push_word (push_word),
    .held      (held)
  );

  wdat_word_fifo #(
    .WORD_W (WORD_W),
    .DEPTH  (DEPTH)
  ) i_fifo (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .push      (push),
    .push_word (push_word),
    .out_vld   (mem_vld),
    .out_rdy   (mem_rdy),
    .out_word  (mem_word),
    .full      (full),
    .fill      (fill)
  );

  assign bus_busy = full;

endmodule

// File: rtl/wdat_assembler_chk.sv
module wdat_assembler_chk #(
  parameter int unsigned WORD_W = 144,
  parameter int unsigned DEPTH  = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       bus_vld,
  input logic                       bus_busy,
  input logic                       held,
  input logic                       push,
  input logic                       mem_vld,
  input logic                       mem_rdy,
  input logic [WORD_W-1:0]          mem_word,
  input logic [$clog2(DEPTH+1)-1:0] fill
);

  // R6
  vld_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_vld && !mem_rdy) |=> (mem_vld && $stable(mem_word)));

  // R7
  busy_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_busy |-> mem_vld);

  // R4
  push_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> mem_vld);

  // R8
  drop_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_vld && bus_busy && !held) |=> !held);

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (int'(fill) < DEPTH || (mem_vld && mem_rdy)));

endmodule

bind wdat_assembler wdat_assembler_chk #(
  .WORD_W (2 * BEAT_W),
  .DEPTH  (DEPTH)
) i_chk (
  .clk      (clk),
  .rst_n    (rst_core_n),
  .bus_vld  (bus_vld),
  .bus_busy (bus_busy),
  .held     (held),
  .push     (push),
  .mem_vld  (mem_vld),
  .mem_rdy  (mem_rdy),
  .mem_word (mem_word),
  .fill     (fill)
);

// File: tb/test_wdat_assembler.sv
module test_wdat_assembler;

  localparam int CLK_PERIOD = 10;
  localparam int BEAT_W     = 72;
  localparam int DEPTH      = 2;
  localparam int W          = 2 * BEAT_W;

  logic              clk;
  logic              rst_n;
  logic              bus_vld;
  logic [BEAT_W-1:0] bus_beat;
  logic              bus_wrap;
  logic              bus_busy;
  logic              mem_vld;
  logic              mem_rdy;
  logic [W-1:0]      mem_word;

  int checks;
  int errors;

  logic [W-1:0]      exp_q[$];
  bit                m_half;
  logic [BEAT_W-1:0] m_first;
  bit                m_wrap;

  wdat_assembler #(.BEAT_W(BEAT_W), .DEPTH(DEPTH)) i_wdat_assembler (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_vld  (bus_vld),
    .bus_beat (bus_beat),
    .bus_wrap (bus_wrap),
    .bus_busy (bus_busy),
    .mem_vld  (mem_vld),
    .mem_rdy  (mem_rdy),
    .mem_word (mem_word)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [W-1:0] join_beats(logic [BEAT_W-1:0] first,
                                              logic [BEAT_W-1:0] second,
                                              bit wrap);
    return wrap ? {first, second} : {second, first};
  endfunction

  function automatic logic [BEAT_W-1:0] rand_beat();
    return {8'($urandom()), $urandom(), $urandom()};
  endfunction

  task automatic chk(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // one cycle: check outputs, drive inputs, advance the reference model
  task automatic step(bit vld, logic [BEAT_W-1:0] beat, bit wrap, bit rdy, string tag);
    bit do_push;
    bit do_pop;
    logic [W-1:0] word;
    @(negedge clk);
    chk(tag, "mem_vld", W'(mem_vld), W'(exp_q.size() > 0));
    if (exp_q.size() > 0) chk(tag, "mem_word", mem_word, exp_q[0]);
    chk(tag, "bus_busy", W'(bus_busy), W'(exp_q.size() == DEPTH));
    bus_vld  = vld;
    bus_beat = beat;
    bus_wrap = wrap;
    mem_rdy  = rdy;
    do_pop  = (exp_q.size() > 0) && rdy;
    do_push = 1'b0;
    word    = '0;
    if (vld && m_half) begin
      do_push = 1'b1;
      word    = join_beats(m_first, beat, m_wrap);
      m_half  = 1'b0;
    end else if (vld && !m_half && exp_q.size() < DEPTH) begin
      m_half  = 1'b1;
      m_first = beat;
      m_wrap  = wrap;
    end
    if (do_pop) void'(exp_q.pop_front());
    if (do_push) exp_q.push_back(word);
  endtask

  task automatic idle(int n, bit rdy, string tag);
    for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, rdy, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [BEAT_W-1:0] a;
    logic [BEAT_W-1:0] b;
    checks  = 0;
    errors  = 0;
    m_half  = 1'b0;
    m_first = '0;
    m_wrap  = 1'b0;
    void'($urandom(32'd20240611));
    rst_n    = 1'b0;
    bus_vld  = 1'b0;
    bus_beat = '0;
    bus_wrap = 1'b0;
    mem_rdy  = 1'b0;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "mem_vld in reset", W'(mem_vld), '0);
    chk("R1", "bus_busy in reset", W'(bus_busy), '0);
    rst_n = 1'b1;
    idle(4, 1'b1, "R1");

    // R2: unwrapped ordering
    a = 72'h11_2233_4455_6677_8899;
    b = 72'hAA_BBCC_DDEE_FF00_1122;
    step(1'b1, a, 1'b0, 1'b1, "R2");
    step(1'b1, b, 1'b1, 1'b1, "R2");
    // R4: word visible the cycle after the second beat edge
    step(1'b0, '0, 1'b0, 1'b1, "R4");
    chk("R2", "unwrapped halves", mem_word, {b, a});

    // R3: wrapped ordering, wrap on second beat ignored
    a = 72'h0F_0F0F_0F0F_0F0F_0F0F;
    b = 72'hF0_F0F0_F0F0_F0F0_F0F0;
    step(1'b1, a, 1'b1, 1'b1, "R3");
    step(1'b1, b, 1'b0, 1'b1, "R3");
    step(1'b0, '0, 1'b0, 1'b1, "R3");
    chk("R3", "wrapped halves", mem_word, {a, b});
    idle(2, 1'b1, "R3");

    // R9: two whole writes accepted with memory stalled
    for (int i = 0; i < 4; i++) step(1'b1, rand_beat(), i[1], 1'b0, "R9");
    // R6 and R7: held stable and busy while stalled
    idle(3, 1'b0, "R6");
    chk("R7", "busy with two words", W'(bus_busy), W'(1));
    // R8: beats offered during busy are dropped
    step(1'b1, rand_beat(), 1'b0, 1'b0, "R8");
    step(1'b1, rand_beat(), 1'b1, 1'b0, "R8");
    // R5: drain in order, no extra words appear
    idle(4, 1'b1, "R5");
    chk("R8", "nothing left after drain", W'(mem_vld), '0);

    // R5: random traffic
    for (int i = 0; i < 4000; i++) begin
      step(($urandom() % 3) != 0, rand_beat(), $urandom() % 2 == 1,
           ($urandom() % 4) != 0, "R5");
    end
    // finish any half write, then drain
    if (m_half) step(1'b1, rand_beat(), 1'b0, 1'b1, "R5");
    idle(5, 1'b1, "R5");
    chk("R5", "empty at end", W'(mem_vld), '0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule